// File: doc/BRIEF.md
# Video Sync Measurement Unit

This block watches a horizontal and a vertical sync input and reports, for each of them, whether it is present, its polarity and how fast it runs. Both inputs pass through a synchronizer and a noise filter that drops any pulse lasting a single clock. Each input's polarity is judged from its duty cycle. The active edge of each input is the leading edge of its sync pulse, which is the falling edge for a negative input and the rising edge for a positive one. Presence checks and frequency counting all work from that active edge.

The horizontal measurement counts 2 MHz ticks across a window of 64 line periods. The vertical measurement counts 62.5 kHz ticks across one frame period. With a 12 MHz clock those ticks come from the dividers 6 and 192. Each result is latched into a count word whose top bit flags overflow. Seven sticky event flags record count changes, presence changes, polarity changes and each vertical leading edge. Software clears a flag by writing a zero to its bit.

Top module: `sync_meas_unit`

## Requirements
- R1: The input filter ignores a pulse that lasts one clock. A pulse held for two clocks or longer is seen as a real level change.
- R2: The horizontal count is written at the end of a window of HLINES (64) active-edge periods of horizontal sync. If T is the window length in clocks, the value is floor((T-1)/HDIV) and goes in bits [HCNT_W-1:0]. Bit HCNT_W is the overflow bit.
- R3: The vertical count is written at every vertical active edge after the first. If P is the frame period in clocks, the value is floor((P-1)/VDIV)+1 and goes in bits [VCNT_W-1:0]. Bit VCNT_W is the overflow bit.
- R4: If a counter runs past its all-ones value, it stays at all ones and the latched word is written with its overflow bit set.
- R5: Flag bit 0 (horizontal) and flag bit 1 (vertical) are set when a newly latched count word differs from the previous one, or when it has its overflow bit set. Latching an identical word without overflow sets neither flag.
- R6: Horizontal present is set on an active edge that comes less than HPRES_SET clocks after the previous active edge. It is cleared after HPRES_CLR clocks with no active edge. Any change of it sets flag bit 2.
- R7: Vertical present follows the same rule with VPRES_SET and VPRES_CLR. Any change of it sets flag bit 3.
- R8: An input's polarity becomes negative (output 1) when its last high phase was longer than the low phase that follows it. Equal phases give positive polarity. The decision is taken at each rising edge of the filtered input. The active edge is the falling edge when the polarity is negative and the rising edge otherwise.
- R9: A change of horizontal polarity sets flag bit 4. A change of vertical polarity sets flag bit 5.
- R10: Every vertical active edge sets flag bit 6.
- R11: While flagWr is high, each zero bit in flagWrData clears the matching flag, and each one bit leaves it as it is. If a flag's event and its clear happen in the same clock, the flag is set.
- R12: After reset, both count words, both present outputs, both polarity outputs and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (12 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| hSyncIn | input | 1 | Horizontal sync input |
| vSyncIn | input | 1 | Vertical sync input |
| flagWr | input | 1 | Flag write strobe |
| flagWrData | input | 7 | Flag write data; a zero bit clears that flag |
| hCount | output | HCNT_W+1 | Latched horizontal count, overflow bit on top |
| vCount | output | VCNT_W+1 | Latched vertical count, overflow bit on top |
| hPresent | output | 1 | Horizontal sync present |
| vPresent | output | 1 | Vertical sync present |
| hPolNeg | output | 1 | Horizontal polarity is negative |
| vPolNeg | output | 1 | Vertical polarity is negative |
| irqFlags | output | 7 | Sticky event flags (bit map in R5 to R10) |

## Verification
The properties assume the following about the inputs:
- Any level that matters lasts at least two clocks.
- Each set threshold is below its clear threshold.
- Polarity settles before counts are compared, because a polarity flip moves the active edge and produces one irregular window.

The stimulus keeps every phase at three clocks or more and changes inputs only at the falling clock edge. It picks random periods that stay below the counter limits, with one deliberate vertical overflow as the exception. After each change it waits at least two full measurement windows before it reads a count.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic hStart;
    logic hLatch;
    logic vStart;
    logic vLatch;
  } measStrobe_t;

  localparam int FLAG_N    = 7;
  localparam int FLG_HFREQ = 0;
  localparam int FLG_VFREQ = 1;
  localparam int FLG_HPRES = 2;
  localparam int FLG_VPRES = 3;
  localparam int FLG_HPOL  = 4;
  localparam int FLG_VPOL  = 5;
  localparam int FLG_VEDGE = 6;

endpackage

// File: rtl/sync_chan_track.sv
// One sync channel: filter, duty-based polarity, active edge, presence.
module sync_chan_track #(
  parameter int DUTY_W   = 16,
  parameter int PRES_SET = 1200,
  parameter int PRES_CLR = 1200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  output logic polNeg,
  output logic present,
  output logic activeEdge,
  output logic polChg,
  output logic presChg
);
  localparam int GAP_W = $clog2(PRES_CLR + 1);
  localparam logic [GAP_W-1:0] SET_LIM = GAP_W'(PRES_SET);
  localparam logic [GAP_W-1:0] CLR_LIM = GAP_W'(PRES_CLR);

  logic [2:0]        syncSh;
  logic              filt, filtD;
  logic              rise, fall, polNext, presSet, presClr;
  logic [DUTY_W-1:0] runLen, highLen;
  logic [GAP_W-1:0]  gap;

  // two-flop synchronizer plus a stage that demands two equal samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSh <= '0;
      filt   <= 1'b0;
      filtD  <= 1'b0;
    end else begin
      syncSh <= {syncSh[1:0], syncIn};
      if (syncSh[1] == syncSh[2]) filt <= syncSh[1];
      filtD <= filt;
    end
  end

  assign rise       = filt & ~filtD;
  assign fall       = ~filt & filtD;
  assign polNext    = (highLen > runLen);
  assign polChg     = rise && (polNext != polNeg);
  assign activeEdge = polNeg ? fall : rise;
  assign presSet    = activeEdge && (gap < SET_LIM);
  assign presClr    = !activeEdge && (gap == CLR_LIM);
  assign presChg    = (presSet && !present) || (presClr && present);

  // phase length measurement and polarity decision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      highLen <= '0;
      polNeg  <= 1'b0;
    end else begin
      if (rise || fall)   runLen <= '0;
      else if (~&runLen)  runLen <= runLen + 1'b1;
      if (fall) highLen <= runLen;
      if (rise) polNeg  <= polNext;
    end
  end

  // presence: interval since the last active edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap     <= '0;
      present <= 1'b0;
    end else begin
      if (activeEdge)          gap <= '0;
      else if (gap != CLR_LIM) gap <= gap + 1'b1;
      if (presSet)      present <= 1'b1;
      else if (presClr) present <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_period_counter.sv
// Prescaled interval counter with saturation, overflow and latch.
module sync_period_counter #(
  parameter int DIV   = 6,
  parameter int W     = 14,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         latch,
  output logic [W:0]   result,
  output logic         changed
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
  localparam logic [W-1:0]  CNT_INIT = W'(START);

  logic [PW-1:0] pre;
  logic [W-1:0]  cnt;
  logic          ovf;

  assign changed = latch && (({ovf, cnt} != result) || ovf);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (start) begin
      pre <= '0;
      cnt <= CNT_INIT;
      ovf <= 1'b0;
    end else if (pre == PRE_LAST) begin
      pre <= '0;
      if (&cnt) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      result <= '0;
    else if (latch) result <= {ovf, cnt};
  end

endmodule

// File: rtl/sync_meas_datapath.sv
module sync_meas_datapath
  import syncmon_pkg::*;
#(
  parameter int HDIV   = 6,
  parameter int VDIV   = 192,
  parameter int HCNT_W = 14,
  parameter int VCNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  measStrobe_t       strobe,
  output logic [HCNT_W:0]   hCount,
  output logic [VCNT_W:0]   vCount,
  output logic              hChanged,
  output logic              vChanged
);

  // line window counts from zero, giving ideal minus one
  sync_period_counter #(.DIV(HDIV), .W(HCNT_W), .START(0)) i_hCnt (
    .clk(clk), .rstN(rstN), .start(strobe.hStart), .latch(strobe.hLatch),
    .result(hCount), .changed(hChanged)
  );

  // frame counts from one, giving the rounded-up tick count
  sync_period_counter #(.DIV(VDIV), .W(VCNT_W), .START(1)) i_vCnt (
    .clk(clk), .rstN(rstN), .start(strobe.vStart), .latch(strobe.vLatch),
    .result(vCount), .changed(vChanged)
  );

endmodule

// File: rtl/sync_meas_ctrl.sv
module sync_meas_ctrl
  import syncmon_pkg::*;
#(
  parameter int HLINES    = 64,
  parameter int DUTY_W    = 16,
  parameter int HPRES_SET = 1200,
  parameter int HPRES_CLR = 1200000,
  parameter int VPRES_SET = 300000,
  parameter int VPRES_CLR = 1200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              flagWr,
  input  logic [FLAG_N-1:0] flagWrData,
  input  logic              hChanged,
  input  logic              vChanged,
  output measStrobe_t       strobe,
  output logic              hPresent,
  output logic              vPresent,
  output logic              hPolNeg,
  output logic              vPolNeg,
  output logic [FLAG_N-1:0] irqFlags
);
  localparam int LW = (HLINES > 1) ? $clog2(HLINES) : 1;
  localparam logic [LW-1:0] LINE_LAST = LW'(HLINES - 1);

  logic hActive, vActive, hPolChg, vPolChg, hPresChg, vPresChg;
  logic hArmed, vArmed, hWrap;
  logic [LW-1:0]     lineCnt;
  logic [FLAG_N-1:0] setVec, clrMask;

  sync_chan_track #(.DUTY_W(DUTY_W), .PRES_SET(HPRES_SET), .PRES_CLR(HPRES_CLR)) i_hTrack (
    .clk(clk), .rstN(rstN), .syncIn(hSyncIn), .polNeg(hPolNeg), .present(hPresent),
    .activeEdge(hActive), .polChg(hPolChg), .presChg(hPresChg)
  );

  sync_chan_track #(.DUTY_W(DUTY_W), .PRES_SET(VPRES_SET), .PRES_CLR(VPRES_CLR)) i_vTrack (
    .clk(clk), .rstN(rstN), .syncIn(vSyncIn), .polNeg(vPolNeg), .present(vPresent),
    .activeEdge(vActive), .polChg(vPolChg), .presChg(vPresChg)
  );

  // window sequencing: the first active edge arms, later ones measure
  assign hWrap         = hArmed && (lineCnt == LINE_LAST);
  assign strobe.hStart = hActive && (hWrap || !hArmed);
  assign strobe.hLatch = hActive && hWrap;
  assign strobe.vStart = vActive;
  assign strobe.vLatch = vActive && vArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hArmed  <= 1'b0;
      vArmed  <= 1'b0;
      lineCnt <= '0;
    end else begin
      if (hActive) begin
        hArmed <= 1'b1;
        if (hWrap || !hArmed) lineCnt <= '0;
        else                  lineCnt <= lineCnt + 1'b1;
      end
      if (vActive) vArmed <= 1'b1;
    end
  end

  // sticky flags, set has priority over a write-zero clear
  always_comb begin
    setVec            = '0;
    setVec[FLG_HFREQ] = hChanged;
    setVec[FLG_VFREQ] = vChanged;
    setVec[FLG_HPRES] = hPresChg;
    setVec[FLG_VPRES] = vPresChg;
    setVec[FLG_HPOL]  = hPolChg;
    setVec[FLG_VPOL]  = vPolChg;
    setVec[FLG_VEDGE] = vActive;
    clrMask           = flagWr ? ~flagWrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlags <= '0;
    else       irqFlags <= (irqFlags & ~clrMask) | setVec;
  end

endmodule

// File: rtl/sync_meas_unit.sv
module sync_meas_unit #(
  parameter int HDIV      = 6,
  parameter int VDIV      = 192,
  parameter int HCNT_W    = 14,
  parameter int VCNT_W    = 12,
  parameter int HLINES    = 64,
  parameter int DUTY_W    = 16,
  parameter int HPRES_SET = 1200,
  parameter int HPRES_CLR = 1200000,
  parameter int VPRES_SET = 300000,
  parameter int VPRES_CLR = 1200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              flagWr,
  input  logic [6:0]        flagWrData,
  output logic [HCNT_W:0]   hCount,
  output logic [VCNT_W:0]   vCount,
  output logic              hPresent,
  output logic              vPresent,
  output logic              hPolNeg,
  output logic              vPolNeg,
  output logic [6:0]        irqFlags
);
  syncmon_pkg::measStrobe_t strobe;
  logic hChanged, vChanged;

  sync_meas_ctrl #(
    .HLINES(HLINES), .DUTY_W(DUTY_W),
    .HPRES_SET(HPRES_SET), .HPRES_CLR(HPRES_CLR),
    .VPRES_SET(VPRES_SET), .VPRES_CLR(VPRES_CLR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .flagWr(flagWr), .flagWrData(flagWrData),
    .hChanged(hChanged), .vChanged(vChanged), .strobe(strobe),
    .hPresent(hPresent), .vPresent(vPresent),
    .hPolNeg(hPolNeg), .vPolNeg(vPolNeg), .irqFlags(irqFlags)
  );

  sync_meas_datapath #(
    .HDIV(HDIV), .VDIV(VDIV), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hCount(hCount), .vCount(vCount),
    .hChanged(hChanged), .vChanged(vChanged)
  );

endmodule

// File: rtl/sync_meas_unit_chk.sv
module sync_meas_unit_chk #(
  parameter int HCNT_W = 14,
  parameter int VCNT_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              flagWr,
  input logic [HCNT_W:0]   hCount,
  input logic [VCNT_W:0]   vCount,
  input logic              hPresent,
  input logic              vPresent,
  input logic              hPolNeg,
  input logic              vPolNeg,
  input logic [6:0]        irqFlags
);

  assert_hovf_saturates_R4: assert property (@(posedge clk) disable iff (!rstN)
    hCount[HCNT_W] |-> (&hCount[HCNT_W-1:0]));

  assert_vovf_saturates_R4: assert property (@(posedge clk) disable iff (!rstN)
    vCount[VCNT_W] |-> (&vCount[VCNT_W-1:0]));

  assert_hcount_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hCount != $past(hCount)) |-> irqFlags[0]);

  assert_vcount_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vCount != $past(vCount)) |-> irqFlags[1]);

  assert_hpres_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hPresent != $past(hPresent)) |-> irqFlags[2]);

  assert_vpres_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vPresent != $past(vPresent)) |-> irqFlags[3]);

  assert_hpol_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hPolNeg != $past(hPolNeg)) |-> irqFlags[4]);

  assert_vpol_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vPolNeg != $past(vPolNeg)) |-> irqFlags[5]);

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> ((irqFlags & $past(irqFlags)) == $past(irqFlags)));

endmodule

bind sync_meas_unit sync_meas_unit_chk #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .flagWr(flagWr), .hCount(hCount), .vCount(vCount),
  .hPresent(hPresent), .vPresent(vPresent), .hPolNeg(hPolNeg), .vPolNeg(vPolNeg),
  .irqFlags(irqFlags)
);

// File: tb/test_sync_meas_unit.sv
module test_sync_meas_unit;
  localparam int HDIV_T = 6;
  localparam int VDIV_T = 4;
  localparam int HCW    = 14;
  localparam int VCW    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSyncIn = 1'b0;
  logic vSyncIn = 1'b0;
  logic flagWr = 1'b0;
  logic [6:0] flagWrData = 7'h7F;
  logic [HCW:0] hCount;
  logic [VCW:0] vCount;
  logic hPresent, vPresent, hPolNeg, vPolNeg;
  logic [6:0] irqFlags;

  int nChk = 0;
  int nFail = 0;
  int hPer = 80, hHi = 40, vPer = 2000, vHi = 1000;
  bit hRun = 1'b0, vRun = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_meas_unit #(
    .HDIV(HDIV_T), .VDIV(VDIV_T), .HCNT_W(HCW), .VCNT_W(VCW), .HLINES(64),
    .DUTY_W(16), .HPRES_SET(1000), .HPRES_CLR(5000),
    .VPRES_SET(8000), .VPRES_CLR(20000)
  ) i_sync_meas_unit (
    .clk(clk), .rstN(rstN), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .flagWr(flagWr), .flagWrData(flagWrData), .hCount(hCount), .vCount(vCount),
    .hPresent(hPresent), .vPresent(vPresent), .hPolNeg(hPolNeg), .vPolNeg(vPolNeg),
    .irqFlags(irqFlags)
  );

  function automatic longint expH(int p);
    return longint'((64 * p - 1) / HDIV_T);
  endfunction

  function automatic longint expV(int p);
    int v;
    v = (p - 1) / VDIV_T + 1;
    if (v > (1 << VCW) - 1) return longint'((1 << VCW) | ((1 << VCW) - 1));
    return longint'(v);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrFlags(logic [6:0] d);
    @(negedge clk);
    flagWr = 1'b1;
    flagWrData = d;
    @(negedge clk);
    flagWr = 1'b0;
    flagWrData = 7'h7F;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin : hGen
    forever begin
      if (hRun) begin
        hSyncIn = 1'b1;
        repeat (hHi) @(negedge clk);
        hSyncIn = 1'b0;
        repeat (hPer - hHi) @(negedge clk);
      end else @(negedge clk);
    end
  end

  initial begin : vGen
    forever begin
      if (vRun) begin
        vSyncIn = 1'b1;
        repeat (vHi) @(negedge clk);
        vSyncIn = 1'b0;
        repeat (vPer - vHi) @(negedge clk);
      end else @(negedge clk);
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [6:0] pre;
    bit oldNeg;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 hCount", hCount, 0);
    chk("R12 vCount", vCount, 0);
    chk("R12 present", {hPresent, vPresent}, 0);
    chk("R12 polarity", {hPolNeg, vPolNeg}, 0);
    chk("R12 flags", irqFlags, 0);

    // R1 single-clock glitch is dropped, two-clock pulse is accepted
    @(negedge clk); vSyncIn = 1'b1;
    @(negedge clk); vSyncIn = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 glitch edge flag", irqFlags[6], 0);
    chk("R1 glitch presence", vPresent, 0);
    @(negedge clk); vSyncIn = 1'b1;
    repeat (2) @(negedge clk); vSyncIn = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 two-clock pulse edge flag", irqFlags[6], 1);

    // R11 write ones keeps, write zero clears only that bit
    pre = irqFlags;
    wrFlags(7'h7F);
    chk("R11 write ones", irqFlags, pre);
    wrFlags(7'h3F);
    chk("R11 write zero", irqFlags, pre & 7'h3F);

    // R2 R3 R6 R7 R8 main rounds: one directed, rest random
    for (int r = 0; r < 4; r++) begin
      if (r > 0) begin
        hPer = $urandom_range(90, 40);
        hHi  = $urandom_range(hPer - 3, 3);
        vPer = $urandom_range(3800, 1000);
        vHi  = $urandom_range(vPer - 3, 3);
      end
      hRun = 1'b1;
      vRun = 1'b1;
      repeat (13000) @(negedge clk);
      chk("R2 hCount", hCount, expH(hPer));
      chk("R3 vCount", vCount, expV(vPer));
      chk("R8 hPolNeg", hPolNeg, (hHi > hPer - hHi) ? 1 : 0);
      chk("R8 vPolNeg", vPolNeg, (vHi > vPer - vHi) ? 1 : 0);
      chk("R6 hPresent", hPresent, 1);
      chk("R7 vPresent", vPresent, 1);
    end

    // R5 steady input leaves change flags clear, R10 edge flag keeps firing
    wrFlags(7'h00);
    repeat (13000) @(negedge clk);
    chk("R5 steady hFreq flag", irqFlags[0], 0);
    chk("R5 steady vFreq flag", irqFlags[1], 0);
    chk("R9 steady polarity flags", irqFlags[5:4], 0);
    chk("R6 steady presence flag", irqFlags[2], 0);
    chk("R10 vertical edge flag", irqFlags[6], 1);

    // R5 R9 period and polarity change on horizontal
    oldNeg = hPolNeg;
    hPer = hPer + 7;
    hHi  = oldNeg ? hPer / 4 : (hPer * 3) / 4;
    wrFlags(7'h00);
    repeat (13000) @(negedge clk);
    chk("R5 hFreq change flag", irqFlags[0], 1);
    chk("R9 hPol change flag", irqFlags[4], 1);
    chk("R8 hPolNeg flipped", hPolNeg, !oldNeg);
    chk("R2 hCount after change", hCount, expH(hPer));

    // R4 vertical overflow
    wrFlags(7'h00);
    vPer = 5000;
    vHi  = 2500;
    repeat (15000) @(negedge clk);
    chk("R4 vCount overflow word", vCount, expV(5000));
    chk("R5 overflow sets vFreq flag", irqFlags[1], 1);
    chk("R8 equal phases positive", vPolNeg, 0);

    // R6 R7 loss of both inputs
    wrFlags(7'h00);
    hRun = 1'b0;
    vRun = 1'b0;
    repeat (23000) @(negedge clk);
    chk("R6 hPresent cleared", hPresent, 0);
    chk("R6 hPres flag", irqFlags[2], 1);
    chk("R7 vPresent cleared", vPresent, 0);
    chk("R7 vPres flag", irqFlags[3], 1);

    // R6 slow horizontal does not set presence
    wrFlags(7'h00);
    hPer = 1500;
    hHi  = 700;
    hRun = 1'b1;
    repeat (6000) @(negedge clk);
    chk("R6 slow input not present", hPresent, 0);
    chk("R6 slow input no flag", irqFlags[2], 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule